// File: doc/BRIEF.md
# Register Stack Frame Manager

This block holds the renaming state of a windowed general register file. Logical registers 0 to 31 are global and pass straight through. Logical registers from 32 upward are relative to the current procedure frame and map into a circular physical stacked file. The manager keeps the frame base, the frame size, the local/output split and the rotating size. It accepts three commands. A call turns the caller's output registers into the callee's frame. An alloc resizes the current frame. A return restores the caller's frame from a small marker history.

Registers of callers that no longer fit in the physical stacked file are spilled to a backing store. Registers a returning caller needs back are filled from it. Spills go oldest first and fills newest first, so the backing store behaves as a stack. Each transfer is one request carrying a physical index, held until it is acknowledged. While any transfer is pending, busy is high and new commands are dropped. Several translation ports look up logical registers against the current frame in parallel.

Top module: `reg_stack_frame_mgr`

## Requirements
- R1: A logical register below 32 maps to the physical register with the same number and is never flagged illegal.
- R2: A logical register r >= 32 maps to physical 32 + ((base + r - 32) mod PHYS_STK), where PHYS_STK is a power of two. After reset, base, frame size, local size and rotating size are all zero.
- R3: A translation port flags illegal when its logical register is at or above 32 + frame size.
- R4: A call (op 2'b01) pushes the marker {size, locals, rotating} and advances the base by the locals count. The new frame size becomes the old size minus the locals, and locals and rotating become zero. The caller's locals become dirty. A call is dropped when HIST_DEPTH markers are already held.
- R5: An alloc (op 2'b10) sets frame size = local + output, locals = local and rotating = rot. It is dropped when local + output exceeds MAX_FRAME or rot exceeds local + output.
- R6: A return (op 2'b11) pops the newest marker, restores size, locals and rotating, and moves the base back by the restored locals count. It is dropped when the history is empty.
- R7: While dirty + frame size exceeds PHYS_STK, a spill request is raised for physical 32 + ((base - dirty) mod PHYS_STK). Each acknowledge retires one dirty register, so the oldest go first.
- R8: On a return whose restored locals exceed the dirty count, the dirty count drops to zero. The missing registers are then fill-requested one at a time, from physical 32 + ((base + missing - 1) mod PHYS_STK) down to the base.
- R9: A spill or fill request keeps its index stable until acknowledged, and spill and fill are never raised together.
- R10: Busy is high exactly while a spill or fill is pending. A command presented while busy has no effect.
- R11: A command with op 2'b00 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 none, 01 call, 10 alloc, 11 return |
| alloc_loc_i | input | FW | Alloc locals count |
| alloc_out_i | input | FW | Alloc outputs count |
| alloc_rot_i | input | FW | Alloc rotating count |
| busy_o | output | 1 | Spill or fill pending |
| rd_lreg_i | input | NPORT x 7 | Logical register per translation port |
| rd_phys_o | output | NPORT x PHW | Physical register per port |
| rd_illegal_o | output | NPORT | Access beyond the current frame |
| frame_sof_o | output | FW | Current frame size |
| frame_sol_o | output | FW | Current locals count |
| frame_sor_o | output | FW | Current rotating count |
| bs_spill_o | output | 1 | Spill request to the backing store |
| bs_fill_o | output | 1 | Fill request from the backing store |
| bs_idx_o | output | PHW | Physical register of the pending transfer |
| bs_ack_i | input | 1 | Backing store acknowledge |

## Verification
The bench builds the block with a 16-entry physical stacked file, a 12-register frame limit, a 4-deep marker history and two translation ports. With these sizes, a few nested allocs overrun the stacked file, so spills, base wrap-around past index 15, fills after deep returns and both history limits (full and empty) come up within tens of cycles. A long stretch of random commands under random acknowledge delays then mixes these cases with commands that arrive while busy.

// File: rtl/rsfm_pkg.sv
package rsfm_pkg;
  localparam int unsigned NGLOB = 32;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_CALL  = 2'b01,
    OP_ALLOC = 2'b10,
    OP_RET   = 2'b11
  } rs_op_e;
endpackage

// File: rtl/rsfm_hist.sv
module rsfm_hist #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 21,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx, wr_idx;

  assign top_idx = IW'(cnt_q - 1'b1);
  assign wr_idx  = IW'(cnt_q);
  assign dout_o  = mem[top_idx];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wr_idx] <= din_i;
  end

  assert_no_push_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_no_push_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/rsfm_xlate.sv
module rsfm_xlate #(
  parameter int unsigned PHYS_STK  = 128,
  parameter int unsigned MAX_FRAME = 96,
  localparam int unsigned PW  = $clog2(PHYS_STK),
  localparam int unsigned FW  = $clog2(MAX_FRAME + 1),
  localparam int unsigned PHW = $clog2(rsfm_pkg::NGLOB + PHYS_STK)
) (
  input  logic [6:0]     lreg_i,
  input  logic [PW-1:0]  bof_i,
  input  logic [FW-1:0]  sof_i,
  output logic [PHW-1:0] phys_o,
  output logic           illegal_o
);
  logic [6:0]    off;
  logic [PW-1:0] sidx;

  always_comb begin
    off  = lreg_i - 7'd32;
    sidx = bof_i + PW'(off);
    if (lreg_i < 7'd32) begin
      phys_o    = PHW'(lreg_i);
      illegal_o = 1'b0;
    end else begin
      phys_o    = PHW'(rsfm_pkg::NGLOB) + PHW'(sidx);
      illegal_o = ({1'b0, off} >= 8'(sof_i));
    end
  end
endmodule

// File: rtl/rsfm_bs_req.sv
module rsfm_bs_req #(
  parameter int unsigned PHYS_STK  = 128,
  parameter int unsigned MAX_FRAME = 96,
  localparam int unsigned PW  = $clog2(PHYS_STK),
  localparam int unsigned FW  = $clog2(MAX_FRAME + 1),
  localparam int unsigned NDW = $clog2(PHYS_STK + 1),
  localparam int unsigned SW  = $clog2(PHYS_STK + MAX_FRAME + 1) + 1,
  localparam int unsigned PHW = $clog2(rsfm_pkg::NGLOB + PHYS_STK)
) (
  input  logic [PW-1:0]  bof_i,
  input  logic [NDW-1:0] ndirty_i,
  input  logic [FW-1:0]  sof_i,
  input  logic [FW-1:0]  fill_cnt_i,
  output logic           over_o,
  output logic           spill_o,
  output logic           fill_o,
  output logic [PHW-1:0] idx_o
);
  logic [PW-1:0] sidx;

  always_comb begin
    over_o  = (SW'(ndirty_i) + SW'(sof_i)) > SW'(PHYS_STK);
    fill_o  = (fill_cnt_i != '0);
    spill_o = !fill_o && over_o;
    // fill walks down from the newest missing register, spill walks up from the oldest dirty one
    if (fill_o) sidx = bof_i + PW'(fill_cnt_i - 1'b1);
    else        sidx = bof_i - PW'(ndirty_i);
    idx_o = PHW'(rsfm_pkg::NGLOB) + PHW'(sidx);
  end
endmodule

// File: rtl/reg_stack_frame_mgr.sv
module reg_stack_frame_mgr #(
  parameter int unsigned PHYS_STK   = 128,
  parameter int unsigned MAX_FRAME  = 96,
  parameter int unsigned HIST_DEPTH = 16,
  parameter int unsigned NPORT      = 2,
  localparam int unsigned PW  = $clog2(PHYS_STK),
  localparam int unsigned FW  = $clog2(MAX_FRAME + 1),
  localparam int unsigned NDW = $clog2(PHYS_STK + 1),
  localparam int unsigned SW  = $clog2(PHYS_STK + MAX_FRAME + 1) + 1,
  localparam int unsigned PHW = $clog2(rsfm_pkg::NGLOB + PHYS_STK)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [1:0]                cmd_op_i,
  input  logic [FW-1:0]             alloc_loc_i,
  input  logic [FW-1:0]             alloc_out_i,
  input  logic [FW-1:0]             alloc_rot_i,
  output logic                      busy_o,
  input  logic [NPORT-1:0][6:0]     rd_lreg_i,
  output logic [NPORT-1:0][PHW-1:0] rd_phys_o,
  output logic [NPORT-1:0]          rd_illegal_o,
  output logic [FW-1:0]             frame_sof_o,
  output logic [FW-1:0]             frame_sol_o,
  output logic [FW-1:0]             frame_sor_o,
  output logic                      bs_spill_o,
  output logic                      bs_fill_o,
  output logic [PHW-1:0]            bs_idx_o,
  input  logic                      bs_ack_i
);
  import rsfm_pkg::*;

  typedef struct packed {
    logic [FW-1:0] sof;
    logic [FW-1:0] sol;
    logic [FW-1:0] sor;
  } frame_mark_t;

  logic [PW-1:0]  bof_q, bof_d;
  logic [FW-1:0]  sof_q, sof_d, sol_q, sol_d, sor_q, sor_d;
  logic [NDW-1:0] nd_q, nd_d;
  logic [FW-1:0]  fc_q, fc_d;
  logic           over;
  logic           h_push, h_pop, h_full, h_empty;
  frame_mark_t    h_din, h_dout;
  logic [FW:0]    a_tot;
  logic           a_ok;

  rsfm_hist #(.DEPTH(HIST_DEPTH), .W($bits(frame_mark_t))) i_hist (
    .clk_i, .rst_ni,
    .push_i (h_push),
    .pop_i  (h_pop),
    .din_i  (h_din),
    .dout_o (h_dout),
    .full_o (h_full),
    .empty_o(h_empty)
  );

  rsfm_bs_req #(.PHYS_STK(PHYS_STK), .MAX_FRAME(MAX_FRAME)) i_bs_req (
    .bof_i     (bof_q),
    .ndirty_i  (nd_q),
    .sof_i     (sof_q),
    .fill_cnt_i(fc_q),
    .over_o    (over),
    .spill_o   (bs_spill_o),
    .fill_o    (bs_fill_o),
    .idx_o     (bs_idx_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rsfm_xlate #(.PHYS_STK(PHYS_STK), .MAX_FRAME(MAX_FRAME)) i_xlate (
      .lreg_i   (rd_lreg_i[p]),
      .bof_i    (bof_q),
      .sof_i    (sof_q),
      .phys_o   (rd_phys_o[p]),
      .illegal_o(rd_illegal_o[p])
    );

    assert_global_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_lreg_i[p] < 7'd32) |-> (rd_phys_o[p] == PHW'(rd_lreg_i[p])) && !rd_illegal_o[p]);
  end

  assign busy_o      = bs_spill_o || bs_fill_o;
  assign frame_sof_o = sof_q;
  assign frame_sol_o = sol_q;
  assign frame_sor_o = sor_q;
  assign h_din       = '{sof: sof_q, sol: sol_q, sor: sor_q};

  always_comb begin
    a_tot = (FW+1)'(alloc_loc_i) + (FW+1)'(alloc_out_i);
    a_ok  = (a_tot <= (FW+1)'(MAX_FRAME)) && ((FW+1)'(alloc_rot_i) <= a_tot);
  end

  always_comb begin
    bof_d  = bof_q;
    sof_d  = sof_q;
    sol_d  = sol_q;
    sor_d  = sor_q;
    nd_d   = nd_q;
    fc_d   = fc_q;
    h_push = 1'b0;
    h_pop  = 1'b0;
    if (bs_fill_o) begin
      if (bs_ack_i) fc_d = fc_q - 1'b1;
    end else if (bs_spill_o) begin
      if (bs_ack_i) nd_d = nd_q - 1'b1;
    end else if (cmd_valid_i) begin
      unique case (rs_op_e'(cmd_op_i))
        OP_CALL: if (!h_full) begin
          h_push = 1'b1;
          bof_d  = bof_q + PW'(sol_q);
          nd_d   = nd_q + NDW'(sol_q);
          sof_d  = sof_q - sol_q;
          sol_d  = '0;
          sor_d  = '0;
        end
        OP_ALLOC: if (a_ok) begin
          sof_d = FW'(a_tot);
          sol_d = alloc_loc_i;
          sor_d = alloc_rot_i;
        end
        OP_RET: if (!h_empty) begin
          h_pop = 1'b1;
          bof_d = bof_q - PW'(h_dout.sol);
          sof_d = h_dout.sof;
          sol_d = h_dout.sol;
          sor_d = h_dout.sor;
          if (SW'(nd_q) >= SW'(h_dout.sol)) begin
            nd_d = nd_q - NDW'(h_dout.sol);
          end else begin
            nd_d = '0;
            fc_d = FW'(SW'(h_dout.sol) - SW'(nd_q));
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bof_q <= '0;
      sof_q <= '0;
      sol_q <= '0;
      sor_q <= '0;
      nd_q  <= '0;
      fc_q  <= '0;
    end else begin
      bof_q <= bof_d;
      sof_q <= sof_d;
      sol_q <= sol_d;
      sor_q <= sor_d;
      nd_q  <= nd_d;
      fc_q  <= fc_d;
    end
  end

  assert_req_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bs_spill_o, bs_fill_o}));
  assert_spill_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_spill_o && !bs_ack_i |=> bs_spill_o && $stable(bs_idx_o));
  assert_fill_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_fill_o && !bs_ack_i |=> bs_fill_o && $stable(bs_idx_o));
  assert_spill_ascend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_spill_o && bs_ack_i && (SW'(nd_q) + SW'(sof_q) > SW'(PHYS_STK + 1))
    |=> bs_spill_o && (bs_idx_o[PW-1:0] == PW'($past(bs_idx_o[PW-1:0]) + 1'b1)));
  assert_fill_descend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_fill_o && bs_ack_i && (fc_q > FW'(1))
    |=> bs_fill_o && (bs_idx_o[PW-1:0] == PW'($past(bs_idx_o[PW-1:0]) - 1'b1)));
  assert_busy_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(frame_sof_o) && $stable(frame_sol_o) && $stable(frame_sor_o) && $stable(bof_q));
  assert_frame_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sol_o <= frame_sof_o) && (frame_sor_o <= frame_sof_o) && (frame_sof_o <= FW'(MAX_FRAME)));
endmodule

// File: tb/test_reg_stack_frame_mgr.sv
module test_reg_stack_frame_mgr;
  localparam int N   = 16;
  localparam int MF  = 12;
  localparam int HD  = 4;
  localparam int NP  = 2;
  localparam int FW  = $clog2(MF + 1);
  localparam int PHW = $clog2(32 + N);

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     cmd_valid_i = 1'b0;
  logic [1:0]               cmd_op_i = 2'b00;
  logic [FW-1:0]            alloc_loc_i = '0, alloc_out_i = '0, alloc_rot_i = '0;
  logic                     busy_o;
  logic [NP-1:0][6:0]       rd_lreg_i = '0;
  logic [NP-1:0][PHW-1:0]   rd_phys_o;
  logic [NP-1:0]            rd_illegal_o;
  logic [FW-1:0]            frame_sof_o, frame_sol_o, frame_sor_o;
  logic                     bs_spill_o, bs_fill_o, bs_ack_i = 1'b0;
  logic [PHW-1:0]           bs_idx_o;

  reg_stack_frame_mgr #(.PHYS_STK(N), .MAX_FRAME(MF), .HIST_DEPTH(HD), .NPORT(NP)) i_reg_stack_frame_mgr (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_op_i, .alloc_loc_i, .alloc_out_i, .alloc_rot_i,
    .busy_o, .rd_lreg_i, .rd_phys_o, .rd_illegal_o, .frame_sof_o, .frame_sol_o, .frame_sor_o,
    .bs_spill_o, .bs_fill_o, .bs_idx_o, .bs_ack_i);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_bof = 0, m_sof = 0, m_sol = 0, m_sor = 0, m_nd = 0, m_fc = 0;
  int hs_sof[$], hs_sol[$], hs_sor[$];
  string tag = "R2 reset";

  function automatic int pmod(int x);
    return ((x % N) + N) % N;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    bit over, fill, spill;
    over  = (m_nd + m_sof) > N;
    fill  = m_fc != 0;
    spill = !fill && over;
    chk("R10 busy", busy_o, fill || over);
    chk("R7 spill", bs_spill_o, spill);
    chk("R8 fill", bs_fill_o, fill);
    if (fill)  chk("R8 R9 fill idx",  bs_idx_o, 32 + pmod(m_bof + m_fc - 1));
    if (spill) chk("R7 R9 spill idx", bs_idx_o, 32 + pmod(m_bof - m_nd));
    chk({tag, " size"},   frame_sof_o, m_sof);
    chk({tag, " locals"}, frame_sol_o, m_sol);
    chk({tag, " rot"},    frame_sor_o, m_sor);
    for (int p = 0; p < NP; p++) begin
      int r;
      r = rd_lreg_i[p];
      if (r < 32) begin
        chk("R1 global phys", rd_phys_o[p], r);
        chk("R1 global legal", rd_illegal_o[p], 0);
      end else begin
        chk("R3 illegal", rd_illegal_o[p], (r >= 32 + m_sof) ? 1 : 0);
        chk("R2 stacked phys", rd_phys_o[p], 32 + pmod(m_bof + r - 32));
      end
    end
  endtask

  task automatic cycle(bit v, bit [1:0] op, int loc, int out, int rot, string t);
    bit ack, over;
    cmd_valid_i = v;
    cmd_op_i    = op;
    alloc_loc_i = FW'(loc);
    alloc_out_i = FW'(out);
    alloc_rot_i = FW'(rot);
    for (int p = 0; p < NP; p++) rd_lreg_i[p] = 7'($urandom_range(0, 50));
    ack = ($urandom_range(0, 2) == 0);
    bs_ack_i = ack;
    over = (m_nd + m_sof) > N;
    if (m_fc != 0) begin
      if (ack) m_fc--;
      if (v) tag = "R10 cmd while busy";
    end else if (over) begin
      if (ack) m_nd--;
      if (v) tag = "R10 cmd while busy";
    end else if (v) begin
      tag = t;
      case (op)
        2'b01: if (hs_sof.size() < HD) begin
          hs_sof.push_back(m_sof); hs_sol.push_back(m_sol); hs_sor.push_back(m_sor);
          m_bof = pmod(m_bof + m_sol);
          m_nd += m_sol;
          m_sof -= m_sol;
          m_sol = 0;
          m_sor = 0;
        end
        2'b10: if (loc + out <= MF && rot <= loc + out) begin
          m_sof = loc + out; m_sol = loc; m_sor = rot;
        end
        2'b11: if (hs_sof.size() > 0) begin
          m_sof = hs_sof.pop_back(); m_sol = hs_sol.pop_back(); m_sor = hs_sor.pop_back();
          m_bof = pmod(m_bof - m_sol);
          if (m_nd >= m_sol) m_nd -= m_sol;
          else begin m_fc = m_sol - m_nd; m_nd = 0; end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic settle();
    for (int i = 0; i < 200 && ((m_fc != 0) || (m_nd + m_sof > N)); i++)
      cycle(0, 2'b00, 0, 0, 0, "R10 drain");
    cycle(0, 2'b00, 0, 0, 0, "R11 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd_lreg_i[0] = 7'd40;
    rd_lreg_i[1] = 7'd5;
    @(negedge clk);
    compare_all();                                    // R2 reset state, R3 with empty frame
    cycle(1, 2'b10, 4, 4, 2, "R5 alloc");   settle();
    cycle(1, 2'b10, 9, 9, 0, "R5 alloc too large"); settle();
    cycle(1, 2'b10, 2, 2, 5, "R5 alloc rot too large"); settle();
    cycle(1, 2'b00, 1, 1, 1, "R11 nop");    settle();
    cycle(1, 2'b01, 0, 0, 0, "R4 call");    settle();
    cycle(1, 2'b10, 6, 6, 4, "R5 alloc");   settle();
    cycle(1, 2'b01, 0, 0, 0, "R4 call");    settle();
    cycle(1, 2'b10, 6, 6, 0, "R7 alloc spills");
    cycle(1, 2'b11, 0, 0, 0, "R10 cmd while busy"); settle();
    cycle(1, 2'b01, 0, 0, 0, "R4 call");    settle();
    cycle(1, 2'b10, 2, 10, 0, "R7 alloc spills wrap"); settle();
    cycle(1, 2'b01, 0, 0, 0, "R4 call");    settle();
    cycle(1, 2'b01, 0, 0, 0, "R4 call history full"); settle();
    for (int k = 0; k < 5; k++) begin
      cycle(1, 2'b11, 0, 0, 0, "R6 R8 return"); settle();
    end
    for (int i = 0; i < 6000; i++) begin
      int sel, lo, ou;
      string t;
      sel = $urandom_range(0, 9);
      lo  = $urandom_range(0, 8);
      ou  = $urandom_range(0, 8);
      if (sel < 3)      begin t = "R4 call";   cycle(1, 2'b01, lo, ou, 0, t); end
      else if (sel < 6) begin t = "R5 alloc";  cycle(1, 2'b10, lo, ou, $urandom_range(0, 6), t); end
      else if (sel < 9) begin t = "R6 return"; cycle(1, 2'b11, lo, ou, 0, t); end
      else              begin t = "R11 nop";   cycle($urandom_range(0, 1) == 1, 2'b00, lo, ou, 1, t); end
    end
    settle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule